// File: doc/BRIEF.md
# Message Byte Packer with Bit-Length Counter

This block sits between a bus write port and a 16-word message FIFO in a hashing engine. Every write to the message window arrives at one entry point. The write carries a 32-bit data word, byte strobes and the two low address bits. The block can byte-swap the word, which it does by default. It then takes the written bytes in message order and packs them into full 32-bit words. The packed words leave on a valid/ready interface whose ready is the FIFO's not-full. When the FIFO cannot take a word that a write would complete, the bus write is held rather than dropped.

A start command opens a message. It clears the byte counter and any partly packed word. Every accepted byte adds 8 to a running 64-bit bit-length. A process command closes the message. If a partial word of 1 to 3 bytes remains, it is pushed with its valid-byte count so that a padder can place the end marker. The close is then signalled by a one-cycle end pulse. Writes that arrive while hashing is disabled are dropped and raise a one-cycle alert.

The controller has three states. `ST_IDLE` accepts no message data. `ST_ACTIVE` packs and counts. `ST_FLUSH` waits for the FIFO to take the final partial word. The transitions are:
- IDLE→ACTIVE on start.
- ACTIVE→ACTIVE on start, which restarts the message.
- ACTIVE→IDLE on process when no partial bytes remain. The end pulse is raised in that cycle.
- ACTIVE→FLUSH on process when partial bytes remain.
- FLUSH→IDLE when the FIFO is ready. The partial word and the end pulse appear in that cycle.

Top module: `msg_packer`

## Requirements
- R1: After reset, `out_valid_o`, `msg_end_o` and `alert_o` are 0, `len_bits_o` is 0, the block is in ST_IDLE and byte swap is enabled.
- R2: With swap enabled, input word w is treated as {w[7:0], w[15:8], w[23:16], w[31:24]} before packing. With swap disabled, the word is used as-is. After this step, message byte k of a word is bits [31-8k -: 8].
- R3: A write supplies n bytes, where n is the number of set strobe bits. They are message byte positions addr..addr+n-1 of the (possibly swapped) word, with addr = `wr_addr_i[1:0]`. They are appended in that order.
- R4: A word is presented on `out_valid_o` in the same cycle as the write that brings the held byte count to 4 or more, with `out_bytes_o` = 4. The first held byte is in bits [31:24]. The excess bytes carry over as the start of the next word. No more than 3 bytes are ever held.
- R5: `len_bits_o` equals 8 times the number of bytes accepted since the last start, updated one cycle after each accepted write. Bits [2:0] are always 0. The value persists after the message ends.
- R6: When a write would complete a word and `out_ready_i` is 0, `wr_ready_o` is 0, and neither the length nor the packed bytes change until the word is taken. A write that completes no word is accepted regardless of `out_ready_i`.
- R7: A process command with 1 to 3 held bytes enters ST_FLUSH. There, `out_valid_o` is 1, `out_data_o` holds those bytes from bit 31 down with zeros below, `out_bytes_o` is the byte count, `wr_ready_o` is 0, and `msg_end_o` pulses in the cycle `out_ready_i` is 1. With no held bytes, `msg_end_o` pulses in the process cycle and no word is pushed.
- R8: A start command clears the byte counter and discards any held bytes. A start or process command stalls a write in the same cycle.
- R9: While `sha_en_i` is 0, writes are accepted (`wr_ready_o` = 1), no word is pushed, the length is unchanged, and `alert_o` is 1 in the following cycle.
- R10: `cfg_we_i` updates the swap setting only in ST_IDLE. Outside ST_IDLE it is ignored.
- R11: In ST_IDLE, writes are accepted and dropped. No word is pushed and the length is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sha_en_i | input | 1 | Hash engine enable; writes are dropped with an alert when 0 |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_swap_i | input | 1 | Byte-swap setting written by `cfg_we_i` |
| start_i | input | 1 | Start-of-message command pulse |
| process_i | input | 1 | End-of-message command pulse |
| wr_valid_i | input | 1 | Bus write request into the message window |
| wr_ready_o | output | 1 | Write accepted this cycle |
| wr_data_i | input | DW | Write data |
| wr_strb_i | input | DW/8 | Byte strobes; count of set bits gives the byte count |
| wr_addr_i | input | 2 | Low address bits; first message byte position |
| out_valid_o | output | 1 | Packed word valid toward the FIFO |
| out_ready_i | input | 1 | FIFO not full |
| out_data_o | output | DW | Packed word, first byte in the top bits |
| out_bytes_o | output | 3 | Valid bytes in `out_data_o` (1 to 4) |
| msg_end_o | output | 1 | One-cycle pulse when the message is closed |
| len_bits_o | output | LEN_W | Message length in bits |
| alert_o | output | 1 | One-cycle pulse after a write dropped with the engine disabled |

## Verification
The bench builds the block with its defaults: a 32-bit word, four byte lanes and a 64-bit length. With those values, every carry case of the packer can be reached with a handful of writes. This includes a three-byte hold followed by a full word, which pushes a straddling word and leaves three bytes again. Each flush byte count of 1 to 3 is also reachable. The wide length counter is checked only for its low values and its zero low bits. Its upper bits are not driven near overflow.

// File: rtl/msg_pack_pkg.sv
package msg_pack_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_FLUSH  = 2'd2
    } pk_state_e;

endpackage

// File: rtl/msg_lane_align.sv
// Swaps (optionally), aligns the addressed byte lanes to the top of the word
// and masks everything past the written byte count.
module msg_lane_align #(
    parameter int DW = 32,
    localparam int NB = DW / 8,
    localparam int AW = $clog2(NB),
    localparam int NW = $clog2(NB + 1)
) (
    input  logic          swap_i,
    input  logic [DW-1:0] data_i,
    input  logic [NB-1:0] strb_i,
    input  logic [AW-1:0] addr_i,
    output logic [DW-1:0] msg_o,
    output logic [NW-1:0] nbytes_o
);

    logic [DW-1:0] swapped;
    logic [DW-1:0] ordered;
    logic [DW-1:0] shifted;

    for (genvar i = 0; i < NB; i++) begin : g_swap
        assign swapped[8*i +: 8] = data_i[8*(NB-1-i) +: 8];
    end

    always_comb begin
        nbytes_o = '0;
        for (int k = 0; k < NB; k++) begin
            nbytes_o = nbytes_o + NW'(strb_i[k]);
        end
    end

    assign ordered = swap_i ? swapped : data_i;
    assign shifted = ordered << {addr_i, 3'b000};

    // message position p sits in bits [DW-1-8p -: 8]
    for (genvar p = 0; p < NB; p++) begin : g_mask
        assign msg_o[DW-1-8*p -: 8] = (NW'(p) < nbytes_o) ? shifted[DW-1-8*p -: 8] : 8'h00;
    end

endmodule

// File: rtl/msg_word_pack.sv
// Holds up to NB-1 bytes and merges new bytes behind them.
module msg_word_pack #(
    parameter int DW = 32,
    localparam int NB = DW / 8,
    localparam int CW = $clog2(NB),
    localparam int NW = $clog2(NB + 1)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          clr_i,
    input  logic          take_i,
    input  logic [DW-1:0] msg_i,
    input  logic [NW-1:0] nbytes_i,
    output logic          fills_o,
    output logic [DW-1:0] word_o,
    output logic [DW-1:0] held_o,
    output logic [CW-1:0] cnt_o
);

    logic [DW-1:0]   acc_q;
    logic [CW-1:0]   cnt_q;
    logic [2*DW-1:0] merged;
    logic [NW-1:0]   total;

    assign merged  = {acc_q, {DW{1'b0}}} | ({msg_i, {DW{1'b0}}} >> {cnt_q, 3'b000});
    assign total   = NW'(cnt_q) + nbytes_i;
    assign fills_o = total >= NW'(NB);
    assign word_o  = merged[2*DW-1 -: DW];
    assign held_o  = acc_q;
    assign cnt_o   = cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            acc_q <= '0;
            cnt_q <= '0;
        end else if (clr_i) begin
            acc_q <= '0;
            cnt_q <= '0;
        end else if (take_i) begin
            if (fills_o) begin
                acc_q <= merged[DW-1:0];
                cnt_q <= CW'(total - NW'(NB));
            end else begin
                acc_q <= merged[2*DW-1 -: DW];
                cnt_q <= CW'(total);
            end
        end
    end

    assert_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |=> (cnt_o == '0));

    assert_carry_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (take_i && !clr_i && !fills_o) |=> (cnt_o >= $past(cnt_o)));

endmodule

// File: rtl/msg_len_count.sv
// Byte counter reported as a bit length.
module msg_len_count #(
    parameter int LEN_W = 64,
    parameter int NW = 3,
    localparam int BCW = LEN_W - 3
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clr_i,
    input  logic             add_i,
    input  logic [NW-1:0]    nbytes_i,
    output logic [LEN_W-1:0] len_bits_o
);

    logic [BCW-1:0] bytes_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            bytes_q <= '0;
        end else if (clr_i) begin
            bytes_q <= '0;
        end else if (add_i) begin
            bytes_q <= bytes_q + BCW'(nbytes_i);
        end
    end

    assign len_bits_o = {bytes_q, 3'b000};

    assert_len_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!add_i && !clr_i) |=> $stable(len_bits_o));

    assert_len_grow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (add_i && !clr_i) |=> (len_bits_o >= $past(len_bits_o)));

endmodule

// File: rtl/msg_packer.sv
module msg_packer
    import msg_pack_pkg::*;
#(
    parameter int DW = 32,
    parameter int LEN_W = 64,
    localparam int NB = DW / 8,
    localparam int AW = $clog2(NB),
    localparam int CW = $clog2(NB),
    localparam int NW = $clog2(NB + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             sha_en_i,
    input  logic             cfg_we_i,
    input  logic             cfg_swap_i,
    input  logic             start_i,
    input  logic             process_i,
    input  logic             wr_valid_i,
    output logic             wr_ready_o,
    input  logic [DW-1:0]    wr_data_i,
    input  logic [NB-1:0]    wr_strb_i,
    input  logic [AW-1:0]    wr_addr_i,
    output logic             out_valid_o,
    input  logic             out_ready_i,
    output logic [DW-1:0]    out_data_o,
    output logic [NW-1:0]    out_bytes_o,
    output logic             msg_end_o,
    output logic [LEN_W-1:0] len_bits_o,
    output logic             alert_o
);

    pk_state_e     state_q, state_d;
    logic          swap_q;
    logic          alert_q;
    logic [DW-1:0] msg_w;
    logic [NW-1:0] nbytes_w;
    logic          fills_w;
    logic [DW-1:0] word_w;
    logic [DW-1:0] held_w;
    logic [CW-1:0] cnt_w;
    logic          take_w;
    logic          pk_clr_w;
    logic          len_clr_w;
    logic          cmd_w;

    assign cmd_w = start_i | process_i;

    msg_lane_align #(.DW(DW)) u_align (
        .swap_i   (swap_q),
        .data_i   (wr_data_i),
        .strb_i   (wr_strb_i),
        .addr_i   (wr_addr_i),
        .msg_o    (msg_w),
        .nbytes_o (nbytes_w)
    );

    msg_word_pack #(.DW(DW)) u_pack (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .clr_i    (pk_clr_w),
        .take_i   (take_w),
        .msg_i    (msg_w),
        .nbytes_i (nbytes_w),
        .fills_o  (fills_w),
        .word_o   (word_w),
        .held_o   (held_w),
        .cnt_o    (cnt_w)
    );

    msg_len_count #(.LEN_W(LEN_W), .NW(NW)) u_len (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .clr_i      (len_clr_w),
        .add_i      (take_w),
        .nbytes_i   (nbytes_w),
        .len_bits_o (len_bits_o)
    );

    // state register and configuration
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
            swap_q  <= 1'b1;
            alert_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (cfg_we_i && state_q == ST_IDLE) begin
                swap_q <= cfg_swap_i;
            end
            alert_q <= wr_valid_i && wr_ready_o && !sha_en_i;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) state_d = ST_ACTIVE;
            end
            ST_ACTIVE: begin
                if (start_i) begin
                    state_d = ST_ACTIVE;
                end else if (process_i) begin
                    state_d = (cnt_w == '0) ? ST_IDLE : ST_FLUSH;
                end
            end
            ST_FLUSH: begin
                if (out_ready_i) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        wr_ready_o  = 1'b0;
        out_valid_o = 1'b0;
        out_data_o  = word_w;
        out_bytes_o = NW'(NB);
        msg_end_o   = 1'b0;
        take_w      = 1'b0;
        pk_clr_w    = 1'b0;
        len_clr_w   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                wr_ready_o = 1'b1;
                pk_clr_w   = start_i;
                len_clr_w  = start_i;
            end
            ST_ACTIVE: begin
                pk_clr_w  = start_i;
                len_clr_w = start_i;
                if (!cmd_w) begin
                    if (!sha_en_i) begin
                        wr_ready_o = 1'b1;
                    end else begin
                        wr_ready_o  = !fills_w || out_ready_i;
                        out_valid_o = wr_valid_i && fills_w;
                        take_w      = wr_valid_i && wr_ready_o;
                    end
                end else if (!start_i && cnt_w == '0) begin
                    msg_end_o = 1'b1;
                end
            end
            ST_FLUSH: begin
                out_valid_o = 1'b1;
                out_data_o  = held_w;
                out_bytes_o = NW'(cnt_w);
                msg_end_o   = out_ready_i;
                pk_clr_w    = out_ready_i;
            end
            default: ;
        endcase
    end

    assign alert_o = alert_q;

    assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_ACTIVE && out_valid_o && !out_ready_i) |-> !wr_ready_o);

    assert_flush_bytes_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_FLUSH) |-> (out_valid_o && out_bytes_o != '0 && out_bytes_o < NW'(NB) && !wr_ready_o));

    assert_alert_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_valid_i && wr_ready_o && !sha_en_i) |=> alert_o);

    assert_cfg_lock_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q != ST_IDLE) |=> $stable(swap_q));

    assert_idle_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_IDLE) |-> (!out_valid_o && !msg_end_o));

    assert_end_onehot_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        msg_end_o |=> !msg_end_o);

endmodule

// File: tb/msg_packer_tb_top.sv
module msg_packer_tb_top;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        sha_en_i = 1'b1;
    logic        cfg_we_i = 1'b0;
    logic        cfg_swap_i = 1'b0;
    logic        start_i = 1'b0;
    logic        process_i = 1'b0;
    logic        wr_valid_i = 1'b0;
    logic        wr_ready_o;
    logic [31:0] wr_data_i = '0;
    logic [3:0]  wr_strb_i = '0;
    logic [1:0]  wr_addr_i = '0;
    logic        out_valid_o;
    logic        out_ready_i = 1'b1;
    logic [31:0] out_data_o;
    logic [2:0]  out_bytes_o;
    logic        msg_end_o;
    logic [63:0] len_bits_o;
    logic        alert_o;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #4 clk_i = ~clk_i;

    msg_packer dut_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .sha_en_i(sha_en_i), .cfg_we_i(cfg_we_i),
        .cfg_swap_i(cfg_swap_i), .start_i(start_i), .process_i(process_i),
        .wr_valid_i(wr_valid_i), .wr_ready_o(wr_ready_o), .wr_data_i(wr_data_i),
        .wr_strb_i(wr_strb_i), .wr_addr_i(wr_addr_i), .out_valid_o(out_valid_o),
        .out_ready_i(out_ready_i), .out_data_o(out_data_o), .out_bytes_o(out_bytes_o),
        .msg_end_o(msg_end_o), .len_bits_o(len_bits_o), .alert_o(alert_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_start();
        start_i = 1'b1;
        @(negedge clk_i);
        start_i = 1'b0;
    endtask

    // write in one cycle; checks comb outputs before the edge
    task automatic wr(input logic [31:0] d, input logic [3:0] s, input logic [1:0] a,
                      input bit push, input logic [31:0] word, input string tag);
        wr_data_i = d; wr_strb_i = s; wr_addr_i = a; wr_valid_i = 1'b1;
        #1;
        chk(wr_ready_o == 1'b1, {tag, " ready"}, 64'(wr_ready_o), 64'd1);
        chk(out_valid_o == push, {tag, " push"}, 64'(out_valid_o), 64'(push));
        if (push) begin
            chk(out_data_o == word, {tag, " word"}, 64'(out_data_o), 64'(word));
            chk(out_bytes_o == 3'd4, {tag, " bytes"}, 64'(out_bytes_o), 64'd4);
        end
        @(negedge clk_i);
        wr_valid_i = 1'b0;
    endtask

    // process command; nb==0 means no partial word expected
    task automatic do_process(input int nb, input logic [31:0] word, input string tag);
        process_i = 1'b1;
        #1;
        chk(out_valid_o == 1'b0, {tag, " no push in cmd cycle"}, 64'(out_valid_o), 64'd0);
        chk(msg_end_o == (nb == 0), {tag, " end in cmd cycle"}, 64'(msg_end_o), 64'(nb == 0));
        @(negedge clk_i);
        process_i = 1'b0;
        if (nb != 0) begin
            #1;
            chk(out_valid_o == 1'b1, {tag, " flush valid"}, 64'(out_valid_o), 64'd1);
            chk(out_data_o == word, {tag, " flush word"}, 64'(out_data_o), 64'(word));
            chk(out_bytes_o == 3'(nb), {tag, " flush bytes"}, 64'(out_bytes_o), 64'(nb));
            chk(msg_end_o == out_ready_i, {tag, " flush end"}, 64'(msg_end_o), 64'(out_ready_i));
            @(negedge clk_i);
        end
    endtask

    task automatic t_reset();
        chk(out_valid_o == 0 && msg_end_o == 0, "R1 outputs idle", {62'd0, out_valid_o, msg_end_o}, 64'd0);
        chk(alert_o == 0, "R1 alert", 64'(alert_o), 64'd0);
        chk(len_bits_o == 0, "R1 length", len_bits_o, 64'd0);
    endtask

    task automatic t_swap_full();
        do_start();
        wr(32'h44332211, 4'hF, 2'd0, 1'b1, 32'h11223344, "R2 default swap");
        chk(len_bits_o == 64'd32, "R5 length 32", len_bits_o, 64'd32);
        do_process(0, 32'h0, "R7 empty close");
    endtask

    task automatic t_bytes();
        do_start();
        chk(len_bits_o == 0, "R8 start clears length", len_bits_o, 64'd0);
        wr(32'h000000AA, 4'b0001, 2'd0, 1'b0, 32'h0, "R3 byte0");
        wr(32'h0000BB00, 4'b0010, 2'd1, 1'b0, 32'h0, "R3 byte1");
        wr(32'h00CC0000, 4'b0100, 2'd2, 1'b0, 32'h0, "R3 byte2");
        wr(32'hDD000000, 4'b1000, 2'd3, 1'b1, 32'hAABBCCDD, "R4 byte3 completes");
        wr(32'h00002211, 4'b0011, 2'd0, 1'b0, 32'h0, "R3 half");
        wr(32'h00330000, 4'b0100, 2'd2, 1'b0, 32'h0, "R3 byte after half");
        chk(len_bits_o == 64'd56, "R5 length 56", len_bits_o, 64'd56);
        chk(len_bits_o[2:0] == 3'd0, "R5 low bits", 64'(len_bits_o[2:0]), 64'd0);
        do_process(3, 32'h11223300, "R7 flush3");
        chk(len_bits_o == 64'd56, "R5 length persists", len_bits_o, 64'd56);
    endtask

    task automatic t_carry();
        do_start();
        wr(32'h0000A2A1, 4'b0011, 2'd0, 1'b0, 32'h0, "R4 carry half");
        wr(32'h00A30000, 4'b0100, 2'd2, 1'b0, 32'h0, "R4 carry byte");
        wr(32'hB4B3B2B1, 4'hF, 2'd0, 1'b1, 32'hA1A2A3B1, "R4 straddle");
        do_process(3, 32'hB2B3B400, "R4 remainder flush");
        chk(len_bits_o == 64'd56, "R5 carry length", len_bits_o, 64'd56);
    endtask

    task automatic t_no_swap();
        cfg_we_i = 1'b1; cfg_swap_i = 1'b0;
        @(negedge clk_i);
        cfg_we_i = 1'b0;
        do_start();
        wr(32'h01020304, 4'hF, 2'd0, 1'b1, 32'h01020304, "R2 swap off");
        wr(32'h00AB0000, 4'b0100, 2'd1, 1'b0, 32'h0, "R3 big-endian lane");
        do_process(1, 32'hAB000000, "R7 flush1");
        cfg_we_i = 1'b1; cfg_swap_i = 1'b1;
        @(negedge clk_i);
        cfg_we_i = 1'b0;
    endtask

    task automatic t_cfg_lock();
        do_start();
        cfg_we_i = 1'b1; cfg_swap_i = 1'b0;
        @(negedge clk_i);
        cfg_we_i = 1'b0;
        wr(32'h44332211, 4'hF, 2'd0, 1'b1, 32'h11223344, "R10 swap kept");
        do_process(0, 32'h0, "R10 close");
    endtask

    task automatic t_backpressure();
        do_start();
        out_ready_i = 1'b0;
        wr_data_i = 32'h44332211; wr_strb_i = 4'hF; wr_addr_i = 2'd0; wr_valid_i = 1'b1;
        #1;
        chk(wr_ready_o == 1'b0, "R6 held", 64'(wr_ready_o), 64'd0);
        chk(out_valid_o == 1'b1, "R6 valid while held", 64'(out_valid_o), 64'd1);
        @(negedge clk_i);
        chk(len_bits_o == 0, "R6 length frozen", len_bits_o, 64'd0);
        out_ready_i = 1'b1;
        #1;
        chk(wr_ready_o == 1'b1, "R6 released", 64'(wr_ready_o), 64'd1);
        chk(out_data_o == 32'h11223344, "R6 word after hold", 64'(out_data_o), 64'h11223344);
        @(negedge clk_i);
        wr_valid_i = 1'b0;
        chk(len_bits_o == 64'd32, "R6 length after release", len_bits_o, 64'd32);
        out_ready_i = 1'b0;
        wr(32'h00000055, 4'b0001, 2'd0, 1'b0, 32'h0, "R6 partial not held");
        process_i = 1'b1;
        @(negedge clk_i);
        process_i = 1'b0;
        wr_valid_i = 1'b1; wr_data_i = 32'h66; wr_strb_i = 4'b0001;
        #1;
        chk(wr_ready_o == 1'b0, "R7 write stalled in flush", 64'(wr_ready_o), 64'd0);
        chk(msg_end_o == 1'b0, "R7 no end while held", 64'(msg_end_o), 64'd0);
        chk(out_data_o == 32'h55000000 && out_bytes_o == 3'd1, "R7 flush word held", 64'(out_data_o), 64'h55000000);
        @(negedge clk_i);
        wr_valid_i = 1'b0;
        out_ready_i = 1'b1;
        #1;
        chk(msg_end_o == 1'b1, "R7 end on ready", 64'(msg_end_o), 64'd1);
        @(negedge clk_i);
        chk(len_bits_o == 64'd40, "R5 length after flush", len_bits_o, 64'd40);
    endtask

    task automatic t_sha_off();
        do_start();
        sha_en_i = 1'b0;
        wr(32'h44332211, 4'hF, 2'd0, 1'b0, 32'h0, "R9 dropped");
        chk(alert_o == 1'b1, "R9 alert pulse", 64'(alert_o), 64'd1);
        chk(len_bits_o == 0, "R9 length unchanged", len_bits_o, 64'd0);
        sha_en_i = 1'b1;
        @(negedge clk_i);
        chk(alert_o == 1'b0, "R9 alert one cycle", 64'(alert_o), 64'd0);
        do_process(0, 32'h0, "R9 nothing held");
    endtask

    task automatic t_restart();
        do_start();
        wr(32'h00000077, 4'b0001, 2'd0, 1'b0, 32'h0, "R8 partial");
        start_i = 1'b1; wr_valid_i = 1'b1;
        #1;
        chk(wr_ready_o == 1'b0, "R8 write stalled by command", 64'(wr_ready_o), 64'd0);
        @(negedge clk_i);
        start_i = 1'b0; wr_valid_i = 1'b0;
        chk(len_bits_o == 0, "R8 restart clears length", len_bits_o, 64'd0);
        do_process(0, 32'h0, "R8 partial discarded");
    endtask

    task automatic t_idle_drop();
        wr(32'h44332211, 4'hF, 2'd0, 1'b0, 32'h0, "R11 idle write");
        chk(len_bits_o == 64'd0, "R11 length unchanged", len_bits_o, 64'd0);
        chk(alert_o == 1'b0, "R11 no alert", 64'(alert_o), 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        @(negedge clk_i);
        t_reset();
        t_swap_full();
        t_bytes();
        t_carry();
        t_no_swap();
        t_cfg_lock();
        t_backpressure();
        t_sha_off();
        t_restart();
        t_idle_drop();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk_i);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule